// File: doc/BRIEF.md
# Multi-Channel ADC Scan Sequencer

This block runs one analog-to-digital converter through a short list of analog inputs. When a scan request arrives, it steps through the list starting at the first entry. For each entry it sets the converter's input multiplexer, waits a programmable number of clocks so the sampled input can settle, and then pulses a start. It waits for the converter's done pulse and repeats the conversion on the same input. The first few results on each input are thrown away, a programmable number of them. The conversion after those is kept. When every entry has a kept value, all result fields are loaded in the same cycle, a one-cycle completion pulse is raised, and the multiplexer goes back to the first list entry.

The block waits for the converter reference to settle. After the enable input rises, it accepts no scan request until enable has been high for a programmable number of clocks. At a 250 MHz clock, 70 µs is 17500 clocks. Dropping enable abandons a scan that is running. Scan requests that arrive while a scan is running are ignored. So are converter done pulses that arrive while no conversion is outstanding.

Top module: `adc_scan_seq`

## Requirements
- R1: While reset is high and on the cycle after it, `mux_sel`, `conv_start`, `scan_done`, `busy` and `results` are all zero.
- R2: A `trigger` is accepted only when `enable` is high and has been high for at least `cfg_settle` rising clock edges. A trigger before that is dropped, and `busy` stays low.
- R3: An accepted `trigger` starts a scan at list entry 0. On the following cycle `busy` is high and `mux_sel` equals entry 0, the low 4 bits of `cfg_chan_list`. Entry k is bits [4k+3:4k].
- R4: Each `conv_start` is a one-cycle pulse. It comes exactly L cycles after the scan starts, after the previous done pulse is taken, or after a channel change. L is `cfg_lead`, with 0 treated as 1. `mux_sel` is stable on the cycle of the pulse.
- R5: Each channel is converted `cfg_discard`+1 times. Only the last of these results is kept.
- R6: `mux_sel` changes in one cycle, straight to a list entry, and never shows an intermediate code.
- R7: A `conv_done` that arrives while no conversion is outstanding has no effect.
- R8: A `trigger` that arrives while `busy` is high has no effect.
- R9: After the last channel's kept result, `scan_done` pulses for one cycle. In that same cycle `busy` falls, `mux_sel` returns to entry 0, and all result fields change together. At no other time do the result fields change.
- R10: The kept result for entry k appears right-aligned in `results[10k+9:10k]`.
- R11: If `enable` falls during a scan, the scan stops, no further `conv_start` is issued, `busy` falls, and `results` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Converter and reference enabled |
| trigger | input | 1 | Scan request pulse |
| cfg_chan_list | input | 8 | Channel list, 4-bit mux code per entry |
| cfg_discard | input | 3 | Number of conversions thrown away per channel |
| cfg_lead | input | 8 | Clocks from mux write to start pulse |
| cfg_settle | input | 16 | Reference settling clocks after enable |
| conv_done | input | 1 | Converter done pulse |
| conv_data | input | 10 | Converter result |
| mux_sel | output | 4 | Converter input select |
| conv_start | output | 1 | Conversion start pulse |
| busy | output | 1 | Scan in progress |
| scan_done | output | 1 | Scan complete pulse |
| results | output | 20 | Kept results, 10 bits per entry |

## Verification
The cases that are hardest to reach from the ports are the ones where an input arrives at an awkward moment. These are a spurious done pulse while the block is idle, a second request in the middle of a scan, and enable dropping while a conversion is still pending in the converter. The bench reaches them with a behavioural converter model whose latency changes from one conversion to the next. It also injects extra done pulses on request and toggles enable partway through a scan. Every converter result carries its input code and a running sequence number. With that, the stored fields show which conversion was kept and from which channel.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_LEAD = 2'd1,
        SQ_WAIT = 2'd2
    } seq_state_t;

    function automatic int unsigned at_least_one(input int unsigned v);
        return (v == 0) ? 1 : v;
    endfunction
endpackage

// File: rtl/adc_scan_settle.sv
module adc_scan_settle #(
    parameter int SETTLE_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                enable,
    input  logic [SETTLE_W-1:0] cfg_settle,
    output logic                ready
);
    logic [SETTLE_W-1:0] elapsed;

    always_ff @(posedge clk) begin
        if (rst || !enable)
            elapsed <= '0;
        else if (elapsed < cfg_settle)
            elapsed <= elapsed + 1'b1;
    end

    assign ready = enable && (elapsed >= cfg_settle);
endmodule

// File: rtl/adc_scan_results.sv
module adc_scan_results #(
    parameter int NUM_CH = 2,
    parameter int RES_W  = 10,
    parameter int IDX_W  = 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    keep_we,
    input  logic [IDX_W-1:0]        keep_idx,
    input  logic [RES_W-1:0]        keep_data,
    input  logic                    commit,
    output logic [NUM_CH*RES_W-1:0] results
);
    for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
        logic [RES_W-1:0] shadow;
        logic [RES_W-1:0] shown;
        logic             hit;

        assign hit = keep_we && (keep_idx == IDX_W'(k));

        always_ff @(posedge clk) begin
            if (rst) begin
                shadow <= '0;
                shown  <= '0;
            end else begin
                if (hit)
                    shadow <= keep_data;
                if (commit)
                    shown <= hit ? keep_data : shadow;
            end
        end

        assign results[k*RES_W +: RES_W] = shown;
    end

    AST_RES_ONLY_ON_COMMIT: assert property (@(posedge clk) disable iff (rst)
        !$stable(results) |-> $past(commit)) else $error("results moved without commit"); // R9
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
    import adc_scan_pkg::*;
#(
    parameter int NUM_CH   = 2,
    parameter int MUX_W    = 4,
    parameter int RES_W    = 10,
    parameter int DISC_W   = 3,
    parameter int LEAD_W   = 8,
    parameter int SETTLE_W = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    enable,
    input  logic                    trigger,
    input  logic [NUM_CH*MUX_W-1:0] cfg_chan_list,
    input  logic [DISC_W-1:0]       cfg_discard,
    input  logic [LEAD_W-1:0]       cfg_lead,
    input  logic [SETTLE_W-1:0]     cfg_settle,
    input  logic                    conv_done,
    input  logic [RES_W-1:0]        conv_data,
    output logic [MUX_W-1:0]        mux_sel,
    output logic                    conv_start,
    output logic                    busy,
    output logic                    scan_done,
    output logic [NUM_CH*RES_W-1:0] results
);
    localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_CH - 1);

    seq_state_t          state;
    logic [IDX_W-1:0]    idx;
    logic [IDX_W-1:0]    next_idx;
    logic [DISC_W-1:0]   conv_num;
    logic [LEAD_W-1:0]   lead_cnt;
    logic [LEAD_W-1:0]   lead_last;
    logic [MUX_W-1:0]    mux_q;
    logic                start_q;
    logic                done_q;
    logic                settle_ok;
    logic                keep_now;
    logic                last_ch;
    logic                keep_we;
    logic                commit;
    logic [MUX_W-1:0]    codes [NUM_CH];
    logic                mux_in_list;

    for (genvar k = 0; k < NUM_CH; k++) begin : g_code
        assign codes[k] = cfg_chan_list[k*MUX_W +: MUX_W];
    end

    adc_scan_settle #(.SETTLE_W(SETTLE_W)) u_settle (
        .clk        (clk),
        .rst        (rst),
        .enable     (enable),
        .cfg_settle (cfg_settle),
        .ready      (settle_ok)
    );

    assign next_idx  = idx + 1'b1;
    assign lead_last = LEAD_W'(at_least_one(32'(cfg_lead)) - 1);
    assign keep_now  = (conv_num == cfg_discard);
    assign last_ch   = (idx == LAST_IDX);
    assign keep_we   = (state == SQ_WAIT) && enable && conv_done && keep_now;
    assign commit    = keep_we && last_ch;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SQ_IDLE;
            idx      <= '0;
            conv_num <= '0;
            lead_cnt <= '0;
            mux_q    <= '0;
            start_q  <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            start_q <= 1'b0;
            done_q  <= 1'b0;
            case (state)
                SQ_IDLE: begin
                    if (trigger && settle_ok) begin
                        state    <= SQ_LEAD;
                        idx      <= '0;
                        conv_num <= '0;
                        lead_cnt <= '0;
                        mux_q    <= codes[0];
                    end
                end
                SQ_LEAD: begin
                    if (!enable) begin
                        state <= SQ_IDLE;
                        idx   <= '0;
                    end else if (lead_cnt == lead_last) begin
                        start_q <= 1'b1;
                        state   <= SQ_WAIT;
                    end else begin
                        lead_cnt <= lead_cnt + 1'b1;
                    end
                end
                SQ_WAIT: begin
                    if (!enable) begin
                        state <= SQ_IDLE;
                        idx   <= '0;
                    end else if (conv_done) begin
                        lead_cnt <= '0;
                        if (keep_now) begin
                            conv_num <= '0;
                            if (last_ch) begin
                                state  <= SQ_IDLE;
                                idx    <= '0;
                                mux_q  <= codes[0];
                                done_q <= 1'b1;
                            end else begin
                                state <= SQ_LEAD;
                                idx   <= next_idx;
                                mux_q <= codes[next_idx];
                            end
                        end else begin
                            conv_num <= conv_num + 1'b1;
                            state    <= SQ_LEAD;
                        end
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    adc_scan_results #(.NUM_CH(NUM_CH), .RES_W(RES_W), .IDX_W(IDX_W)) u_results (
        .clk       (clk),
        .rst       (rst),
        .keep_we   (keep_we),
        .keep_idx  (idx),
        .keep_data (conv_data),
        .commit    (commit),
        .results   (results)
    );

    assign mux_sel    = mux_q;
    assign conv_start = start_q;
    assign scan_done  = done_q;
    assign busy       = (state != SQ_IDLE);

    always_comb begin
        mux_in_list = 1'b0;
        for (int k = 0; k < NUM_CH; k++)
            if (mux_q == codes[k]) mux_in_list = 1'b1;
    end

    AST_START_SETTLED: assert property (@(posedge clk) disable iff (rst)
        conv_start |-> $past(settle_ok)) else $error("start before settling"); // R2
    AST_START_IN_SCAN: assert property (@(posedge clk) disable iff (rst)
        conv_start |-> busy) else $error("start outside scan"); // R3
    AST_MUX_HELD_AT_START: assert property (@(posedge clk) disable iff (rst)
        conv_start |-> $stable(mux_sel)) else $error("mux moved at start"); // R4
    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        conv_start |=> !conv_start) else $error("start too long"); // R4
    AST_MUX_LEGAL: assert property (@(posedge clk) disable iff (rst)
        !$stable(mux_sel) |-> mux_in_list) else $error("mux shows non-list code"); // R6
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        scan_done |=> !scan_done) else $error("scan_done too long"); // R9
    AST_DONE_ENDS_SCAN: assert property (@(posedge clk) disable iff (rst)
        scan_done |-> (!busy && mux_sel == codes[0])) else $error("scan end state"); // R9
endmodule

// File: tb/adc_scan_seq_test.sv
`timescale 1ns/1ps
module adc_scan_seq_test;
    localparam int N = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enable = 1'b0;
    logic        trigger = 1'b0;
    logic [7:0]  cfg_chan_list = {4'd7, 4'd6};
    logic [2:0]  cfg_discard = 3'd1;
    logic [7:0]  cfg_lead = 8'd3;
    logic [15:0] cfg_settle = 16'd40;
    logic        conv_done = 1'b0;
    logic [9:0]  conv_data = '0;
    logic [3:0]  mux_sel;
    logic        conv_start;
    logic        busy;
    logic        scan_done;
    logic [19:0] results;

    adc_scan_seq uut (
        .clk(clk), .rst(rst), .enable(enable), .trigger(trigger),
        .cfg_chan_list(cfg_chan_list), .cfg_discard(cfg_discard),
        .cfg_lead(cfg_lead), .cfg_settle(cfg_settle),
        .conv_done(conv_done), .conv_data(conv_data),
        .mux_sel(mux_sel), .conv_start(conv_start), .busy(busy),
        .scan_done(scan_done), .results(results)
    );

    always #2 clk = ~clk;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit finished = 1'b0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // behavioural converter
    int  seq = 0;
    int  starts = 0;
    int  pend = 0;
    bit  spur_req = 1'b0;
    logic [3:0] pend_code = '0;

    always @(negedge clk) begin
        conv_done <= 1'b0;
        if (spur_req) begin
            spur_req  = 1'b0;
            conv_done <= 1'b1;
            conv_data <= 10'h3FF;
        end else if (conv_start) begin
            starts++;
            pend      = 2 + (starts % 3);
            pend_code = mux_sel;
        end else if (pend > 0) begin
            pend--;
            if (pend == 0) begin
                conv_done <= 1'b1;
                conv_data <= {pend_code, 6'(seq)};
                seq++;
            end
        end
    end

    // cycle-level reference model
    int   m_settle = 0, m_st = 0, m_idx = 0, m_num = 0, m_lc = 0;
    logic [3:0] m_mux = '0;
    bit   m_start = 0, m_done = 0;
    logic [9:0] m_shadow [N];
    logic [9:0] m_res [N];
    bit   model_live = 0;

    function automatic logic [3:0] entry(input int k);
        return cfg_chan_list[k*4 +: 4];
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_settle = 0; m_st = 0; m_idx = 0; m_num = 0; m_lc = 0;
            m_mux = '0; m_start = 0; m_done = 0;
            for (int k = 0; k < N; k++) begin m_shadow[k] = '0; m_res[k] = '0; end
        end else begin
            bit ready;
            int leff;
            ready = enable && (m_settle >= int'(cfg_settle));
            if (!enable) m_settle = 0;
            else if (m_settle < int'(cfg_settle)) m_settle++;
            leff = (cfg_lead == 0) ? 1 : int'(cfg_lead);
            m_start = 0; m_done = 0;
            if (m_st == 0) begin
                if (trigger && ready) begin
                    m_st = 1; m_idx = 0; m_num = 0; m_lc = 0; m_mux = entry(0);
                end
            end else if (!enable) begin
                m_st = 0; m_idx = 0;
            end else if (m_st == 1) begin
                if (m_lc == leff - 1) begin m_start = 1; m_st = 2; end
                else m_lc++;
            end else if (conv_done) begin
                m_lc = 0;
                if (m_num == int'(cfg_discard)) begin
                    m_shadow[m_idx] = conv_data;
                    m_num = 0;
                    if (m_idx == N - 1) begin
                        for (int k = 0; k < N; k++) m_res[k] = m_shadow[k];
                        m_st = 0; m_idx = 0; m_mux = entry(0); m_done = 1;
                    end else begin
                        m_idx++; m_mux = entry(m_idx); m_st = 1;
                    end
                end else begin
                    m_num++; m_st = 1;
                end
            end
        end
        model_live = 1;
    end

    // per-cycle comparison and lead monitor
    int chg_cyc = 0;
    logic [3:0] prev_mux = '0;
    always @(negedge clk) begin
        if (model_live && !finished) begin
            logic [19:0] mres;
            for (int k = 0; k < N; k++) mres[k*10 +: 10] = m_res[k];
            check("R6 mux_sel vs model", 32'(mux_sel), 32'(m_mux));
            check("R4 conv_start vs model", 32'(conv_start), 32'(m_start));
            check("R9 scan_done vs model", 32'(scan_done), 32'(m_done));
            check("R8 busy vs model", 32'(busy), 32'(m_st != 0));
            check("R10 results vs model", 32'(results), 32'(mres));
            if (mux_sel !== prev_mux) chg_cyc = cyc;
            prev_mux = mux_sel;
            if (conv_start) begin
                int leff;
                leff = (cfg_lead == 0) ? 1 : int'(cfg_lead);
                check("R4 lead time reached", 32'((cyc - chg_cyc) >= leff), 32'd1);
            end
        end
    end

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_trigger();
        @(negedge clk) trigger = 1'b1;
        @(negedge clk) trigger = 1'b0;
    endtask

    task automatic run_scan(input bool_extra);
        int base, s0, d;
        int guard;
        wait_cycles(12);
        base = seq; s0 = starts; d = int'(cfg_discard);
        @(negedge clk) trigger = 1'b1;
        @(negedge clk) trigger = 1'b0;
        check("R3 busy after trigger", 32'(busy), 32'd1);
        check("R3 mux on entry 0", 32'(mux_sel), 32'(cfg_chan_list[3:0]));
        guard = 0;
        while (!scan_done && guard < 4000) begin
            @(negedge clk);
            guard++;
            if (bool_extra && guard == 15) begin
                trigger = 1'b1;
                @(negedge clk) trigger = 1'b0;
            end
        end
        check("R9 scan_done seen", 32'(scan_done), 32'd1);
        check("R5 conversions per scan", 32'(starts - s0), 32'(N * (d + 1)));
        for (int k = 0; k < N; k++)
            check("R10 R5 kept field", 32'(results[k*10 +: 10]),
                  32'({cfg_chan_list[k*4 +: 4], 6'(base + k * (d + 1) + d)}));
        @(negedge clk);
        check("R9 done is one cycle", 32'(scan_done), 32'd0);
        check("R9 mux back to entry 0", 32'(mux_sel), 32'(cfg_chan_list[3:0]));
        check("R9 busy low", 32'(busy), 32'd0);
        if (bool_extra) begin
            s0 = starts;
            wait_cycles(60);
            check("R8 no second scan", 32'(starts - s0), 32'd0);
        end
    endtask

    initial begin
        logic [19:0] held;
        wait_cycles(3);
        check("R1 reset mux", 32'(mux_sel), 32'd0);
        check("R1 reset outputs", 32'({conv_start, busy, scan_done}), 32'd0);
        check("R1 reset results", 32'(results), 32'd0);
        @(negedge clk) rst = 1'b0;
        @(negedge clk);
        check("R1 after reset", 32'({mux_sel, conv_start, busy, scan_done}), 32'd0);

        enable = 1'b1;
        wait_cycles(5);
        pulse_trigger();
        wait_cycles(3);
        check("R2 early trigger dropped", 32'(busy), 32'd0);
        wait_cycles(40);

        run_scan(1'b0);
        cfg_discard = 3'd0; cfg_lead = 8'd0;
        run_scan(1'b0);
        cfg_discard = 3'd3; cfg_lead = 8'd5; cfg_chan_list = {4'd2, 4'd9};
        run_scan(1'b1);

        held = results;
        @(negedge clk) spur_req = 1'b1;
        wait_cycles(4);
        check("R7 stray done ignored", 32'(results), 32'(held));
        check("R7 no scan_done", 32'(busy), 32'd0);

        cfg_chan_list = {4'd7, 4'd6};
        pulse_trigger();
        wait_cycles(10);
        enable = 1'b0;
        wait_cycles(2);
        check("R11 busy falls on disable", 32'(busy), 32'd0);
        wait_cycles(20);
        check("R11 results kept", 32'(results), 32'(held));
        enable = 1'b1;
        wait_cycles(45);
        cfg_discard = 3'd1; cfg_lead = 8'd2;
        run_scan(1'b0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    initial begin
        wait (cyc > 150000);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end
endmodule